// File: doc/BRIEF.md
# GPIO Port Register Bank with Bit-Set, Bit-Clear and Bit-Toggle Aliases

The block is a memory-mapped general-purpose I/O port behind a simple single-cycle 32-bit bus slave. It keeps two pin-wide registers. One is the drive-enable register, which is active low: a zero bit drives the pin. The other is the output-level register. Software can reach each register through four word addresses. One address replaces the whole register. The other three set, clear or invert only the bits that are one in the written word. Software can therefore change a single pin without a read-modify-write sequence, and it cannot race another agent that owns the other pins.

A read-only word returns the pin levels after a two-stage synchronizer. The block drives the output levels and the active-low enables straight from its registers to an external pad ring. Reads are combinational and have no side effects. A write takes effect on the clock edge where select and write-enable are both high.

Top module: `gpio_alias_bank`

## Requirements
- R1: While reset is asserted and after it is released, the output-level register reads zero and the drive-enable register reads all ones, so no pin is driven.
- R2: A write to the replace alias loads the written word into the register: offset 0x00 for the enable register, offset 0x10 for the level register.
- R3: A write to the set alias ORs the written mask into the register: offset 0x04 for enable, 0x14 for level.
- R4: A write to the clear alias clears the bits that are one in the mask and keeps all other bits: offset 0x08 for enable, 0x18 for level.
- R5: A write to the toggle alias XORs the mask into the register: offset 0x0C for enable, 0x1C for level.
- R6: pin_oe_n always equals the enable register and pin_out always equals the level register. Writing the complement of a mask to offset 0x00 drives exactly the pins in that mask.
- R7: A read of any of a register's four aliases returns that register's current value in the low bits, with zeros above. Address bits [1:0] are ignored.
- R8: A read of offset 0x20 returns pin_in as it was sampled two rising clock edges earlier. A change on the pins is not visible after only one edge.
- R9: Reads of unmapped word offsets (0x24 and above) return zero. Writes to 0x20 or to unmapped offsets change neither register.
- R10: A register changes only on an edge where bus_sel and bus_we are both high. Reads and unselected writes change nothing.
- R11: An access to one register's aliases leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released in step with clk |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data or bit mask |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| pin_in | input | PIN_W | Pad input levels, asynchronous |
| pin_out | output | PIN_W | Output level per pin |
| pin_oe_n | output | PIN_W | Active-low drive enable per pin |

## Verification
Both registers drive pins directly, so a wrong bit in either register appears on pin_out or pin_oe_n at the next sample after the faulty edge. The same bit also shows on every read alias of that register. A decoding fault that points an alias at the wrong register or the wrong operation changes the other register or gives the wrong mask result within one write. A synchronizer that is one stage too short or too long moves the edge on which the input word first shows a new pin value by one cycle. A sweep that samples after one edge and after two edges detects this.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  // Alias operation, taken from byte-address bits [3:2].
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  // Which storage the decoded word offset reaches.
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_ENABLE = 2'd1,
    TGT_LEVEL  = 2'd2,
    TGT_INPUT  = 2'd3
  } target_e;

  typedef struct packed {
    target_e   tgt;
    alias_op_e op;
  } access_t;

endpackage

// File: rtl/gpio_alias_decode.sv
module gpio_alias_decode
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output access_t           acc
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    acc.tgt = TGT_NONE;
    acc.op  = alias_op_e'(word[1:0]);
    if (word < WORD_W'(8)) begin
      acc.tgt = word[2] ? TGT_LEVEL : TGT_ENABLE;
    end else if (word == WORD_W'(8)) begin
      acc.tgt = TGT_INPUT;
    end
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_alias_pkg::*;
#(
  parameter int           W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    unique case (op)
      OP_WRITE:  q_nxt = mask;
      OP_SET:    q_nxt = q | mask;
      OP_CLEAR:  q_nxt = q & ~mask;
      OP_TOGGLE: q_nxt = q ^ mask;
      default:   q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_VAL;
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_alias_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe_n
);
  localparam int SYNC_STAGES = 2;

  access_t          acc;
  logic             wr_strobe;
  logic             wr_enable_reg;
  logic             wr_level_reg;
  logic [PIN_W-1:0] mask;
  logic [PIN_W-1:0] enable_q;
  logic [PIN_W-1:0] level_q;
  logic [PIN_W-1:0] pins_sync;

  gpio_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .acc  (acc)
  );

  assign wr_strobe     = bus_sel & bus_we;
  assign wr_enable_reg = wr_strobe && (acc.tgt == TGT_ENABLE);
  assign wr_level_reg  = wr_strobe && (acc.tgt == TGT_LEVEL);
  assign mask          = bus_wdata[PIN_W-1:0];

  gpio_alias_reg #(.W(PIN_W), .RESET_VAL({PIN_W{1'b1}})) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_enable_reg),
    .op    (acc.op),
    .mask  (mask),
    .q     (enable_q)
  );

  gpio_alias_reg #(.W(PIN_W), .RESET_VAL({PIN_W{1'b0}})) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_level_reg),
    .op    (acc.op),
    .mask  (mask),
    .q     (level_q)
  );

  gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (acc.tgt)
      TGT_ENABLE: bus_rdata[PIN_W-1:0] = enable_q;
      TGT_LEVEL:  bus_rdata[PIN_W-1:0] = level_q;
      TGT_INPUT:  bus_rdata[PIN_W-1:0] = pins_sync;
      default:    bus_rdata = '0;
    endcase
  end

  assign pin_out  = level_q;
  assign pin_oe_n = enable_q;
endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk #(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe_n
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_set_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'('h14)) |=>
      pin_out == ($past(pin_out) | $past(bus_wdata[PIN_W-1:0])));

  p_clear_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'('h08)) |=>
      pin_oe_n == ($past(pin_oe_n) & ~$past(bus_wdata[PIN_W-1:0])));

  p_toggle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'('h1C)) |=>
      pin_out == ($past(pin_out) ^ $past(bus_wdata[PIN_W-1:0])));

  p_enable_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == ADDR_W'('h00)) |->
      bus_rdata[PIN_W-1:0] == pin_oe_n);

  p_input_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && bus_addr == ADDR_W'('h20)) |->
      bus_rdata[PIN_W-1:0] == $past(pin_in, 2));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h24)) |-> bus_rdata == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> ($stable(pin_out) && $stable(pin_oe_n)));
endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe_n  (pin_oe_n)
);

// File: tb/tb_gpio_alias_bank.sv
module tb_gpio_alias_bank;
  localparam int PIN_W  = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              bus_sel;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic [PIN_W-1:0]  pin_in;
  logic [PIN_W-1:0]  pin_out;
  logic [PIN_W-1:0]  pin_oe_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  gpio_alias_bank #(.PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] apply(input int op, input logic [7:0] q, input logic [7:0] m);
    case (op)
      0:       return m;
      1:       return q | m;
      2:       return q & ~m;
      default: return q ^ m;
    endcase
  endfunction

  initial begin
    logic [31:0] r;
    logic [7:0]  starts [4];
    starts[0] = 8'h00; starts[1] = 8'hFF; starts[2] = 8'hA5; starts[3] = 8'h3C;
    rst_n = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 level in reset", {24'h0, pin_out}, 32'h0);
    chk("R1 enable in reset", {24'h0, pin_oe_n}, 32'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, r); chk("R1 level read", r, 32'h0);
    rd(8'h00, r); chk("R1 enable read", r, 32'hFF);

    // R6: enable only pins 4 and 5 by writing the complement
    wr(8'h00, ~32'h30);
    chk("R6 oe_n complement", {24'h0, pin_oe_n}, 32'hCF);

    // R2..R5, R7, R11: sweep every mask for each register, alias, start value
    for (int g = 0; g < 2; g++) begin
      for (int op = 0; op < 4; op++) begin
        for (int s = 0; s < 4; s++) begin
          wr(g ? 8'h00 : 8'h10, 32'h5A);
          for (int m = 0; m < 256; m++) begin
            logic [7:0] exp;
            logic [7:0] base;
            base = g ? 8'h10 : 8'h00;
            wr(base, {24'h0, starts[s]});
            wr(base + 8'(op * 4), {24'hFFFFFF, 8'(m)});
            exp = apply(op, starts[s], 8'(m));
            case (op)
              0: chk("R2 replace", {24'h0, g ? pin_out : pin_oe_n}, {24'h0, exp});
              1: chk("R3 set", {24'h0, g ? pin_out : pin_oe_n}, {24'h0, exp});
              2: chk("R4 clear", {24'h0, g ? pin_out : pin_oe_n}, {24'h0, exp});
              default: chk("R5 toggle", {24'h0, g ? pin_out : pin_oe_n}, {24'h0, exp});
            endcase
            rd(base + 8'(((op + m) % 4) * 4) + 8'(m % 4), r);
            chk("R7 alias read", r, {24'h0, exp});
          end
          chk("R11 other register", {24'h0, g ? pin_oe_n : pin_out}, 32'h5A);
        end
      end
    end

    // R8: synchronizer latency
    wr(8'h10, 32'h0);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h3C;
    rd(8'h20, r); chk("R8 before edge", r, 32'h0);
    rd(8'h20, r); chk("R8 after one edge", r, 32'h0);
    rd(8'h20, r); chk("R8 after two edges", r, 32'h3C);
    for (int v = 0; v < 256; v++) begin
      pin_in = 8'(v);
      repeat (2) @(negedge clk);
      rd(8'h20, r); chk("R8 sweep", r, v);
    end

    // R9: unmapped reads zero, writes to input/unmapped are ignored
    wr(8'h10, 32'h96); wr(8'h00, 32'h69);
    for (int a = 8'h24; a < 256; a += 4) begin
      rd(8'(a), r); chk("R9 unmapped read", r, 32'h0);
    end
    for (int a = 8'h20; a < 256; a += 4) begin
      wr(8'(a), 32'hFFFFFFFF);
    end
    chk("R9 level kept", {24'h0, pin_out}, 32'h96);
    chk("R9 enable kept", {24'h0, pin_oe_n}, 32'h69);

    // R10: reads and unselected writes change nothing
    for (int a = 0; a < 8'h20; a += 4) begin
      rd(8'(a), r);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 32'hFF;
      @(negedge clk);
      bus_we = 1'b0;
    end
    chk("R10 level kept", {24'h0, pin_out}, 32'h96);
    chk("R10 enable kept", {24'h0, pin_oe_n}, 32'h69);

    // R1: reset in mid-run restores defaults
    rst_n = 1'b0;
    #1;
    chk("R1 async level", {24'h0, pin_out}, 32'h0);
    chk("R1 async enable", {24'h0, pin_oe_n}, 32'hFF);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule